// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives seventeen extra output bits through an external serial-in/parallel-out shift register. It makes a serial clock and a serial data line from the system clock, divided by a selectable power of two. A programmable delay sets where the rising serial clock edge falls after each data change.

There are two ways to start a transfer. In direct mode, a write of a 17-bit word starts one shift-out, and a busy flag stays high until the transfer and its closing delay are over. In flash mode, the controller watches a 17-bit vector of PWM channel outputs. It shifts the vector out on its own whenever the vector differs from the word that was shifted last. After reset the last word is all zeros, so flash mode sends nothing until some bit must go high.

A latch-mode input selects chips that need a parallel-load strobe. When it is set, the controller gives a one-cycle strobe at the end of each transfer.

Top module: `serial_led_shifter`

## Requirements
- R1: After reset, and whenever busy is low, busy, ser_clk, ser_data and ser_latch are all 0.
- R2: A data_wr pulse while idle shifts out data_in, bit 16 first. ser_clk gives exactly 17 rising edges, and the bit on ser_data at each rising edge is the next bit of the word.
- R3: div_code selects the system clocks per serial bit as D = 4 << div_code: code 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. busy stays high for exactly 17*D + d + 1 cycles, where d is the effective delay.
- R4: The rising ser_clk edge comes d+1 clocks after each data change, and ser_data is stable at that edge. The effective delay d is clk_delay limited to D/2 - 1.
- R5: A data_wr pulse while busy is ignored. The word in progress is sent unchanged, and no second transfer follows.
- R6: With flash_en set, no transfer starts while pwm_vec equals the last word shifted out. After reset that word is all zeros.
- R7: With flash_en set and the block idle, a pwm_vec that differs from the last word shifted out starts a transfer of pwm_vec. This includes a change back to all zeros.
- R8: With flash_en clear, changes on pwm_vec start no transfer.
- R9: With latch_mode set at the start of a transfer, ser_latch pulses for exactly one cycle, in the last busy cycle. With latch_mode clear it stays 0.
- R10: div_code, clk_delay and latch_mode are captured when a transfer starts. Changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr | input | 1 | Direct write strobe |
| data_in | input | 17 | Direct word to shift out |
| div_code | input | 2 | Serial clock divider select |
| clk_delay | input | 5 | Data-to-clock edge delay |
| flash_en | input | 1 | Automatic refresh from pwm_vec |
| latch_mode | input | 1 | Emit end-of-transfer strobe |
| pwm_vec | input | 17 | PWM channel outputs for flash mode |
| busy | output | 1 | Transfer in progress |
| ser_clk | output | 1 | Serial clock to the shift chip |
| ser_data | output | 1 | Serial data to the shift chip |
| ser_latch | output | 1 | Parallel-load strobe |

## Verification
The case hardest to reach from the ports is a write that lands while a transfer is running, together with configuration changes in the same window. A correct design must ignore both.

The bench starts a slow transfer and waits until it is well under way. It then pulses data_wr with a different word and moves div_code to its slowest code. Afterwards it checks three things: the received word, the busy length, which must match the original divider, and a quiet period after busy falls.

Flash mode is driven through the reset all-zero vector, a new vector, a repeated vector, a return to zero, and changes made with flash_en clear.

// File: rtl/serial_led_shifter.sv
module serial_led_shifter #(
  parameter int NBITS = 17,
  parameter int DLY_W = 5,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [NBITS-1:0] data_in,
  input  logic [1:0]       div_code,
  input  logic [DLY_W-1:0] clk_delay,
  input  logic             flash_en,
  input  logic             latch_mode,
  input  logic [NBITS-1:0] pwm_vec,
  output logic             busy,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             ser_latch
);
  localparam int IW = $clog2(NBITS);

  logic             busy_q, tail_q, mode_q;
  logic [CW-1:0]    cnt_q, dly_q;
  logic [IW-1:0]    idx_q;
  logic [NBITS-1:0] sh_q, last_q;
  logic [1:0]       div_q;

  wire [CW-1:0] in_len  = CW'(4) << div_code;
  wire [CW-1:0] in_lim  = (in_len >> 1) - CW'(1);
  wire [CW-1:0] in_dly  = (CW'(clk_delay) > in_lim) ? in_lim : CW'(clk_delay);
  wire [CW-1:0] cur_len = CW'(4) << div_q;
  wire [CW-1:0] cur_half = cur_len >> 1;

  wire start_dir = !busy_q && data_wr;
  wire start_fl  = !busy_q && !data_wr && flash_en && (pwm_vec != last_q);
  wire [NBITS-1:0] start_word = start_dir ? data_in : pwm_vec;
  wire shifting  = busy_q && !tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
      dly_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      last_q <= '0;
      div_q  <= '0;
    end else if (!busy_q) begin
      if (start_dir || start_fl) begin
        busy_q <= 1'b1;
        tail_q <= 1'b0;
        cnt_q  <= '0;
        idx_q  <= IW'(NBITS-1);
        sh_q   <= start_word;
        last_q <= start_word;
        div_q  <= div_code;
        dly_q  <= in_dly;
        mode_q <= latch_mode;
      end
    end else if (!tail_q) begin
      if (cnt_q == cur_len - CW'(1)) begin
        cnt_q <= '0;
        if (idx_q == '0) begin
          tail_q <= 1'b1;
        end else begin
          idx_q <= idx_q - IW'(1);
          sh_q  <= sh_q << 1;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else begin
      if (cnt_q == dly_q) begin
        busy_q <= 1'b0;
        tail_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign busy      = busy_q;
  assign ser_clk   = shifting && (cnt_q > dly_q) && (cnt_q <= dly_q + cur_half);
  assign ser_data  = shifting && sh_q[NBITS-1];
  assign ser_latch = mode_q && busy_q && tail_q && (cnt_q == dly_q);
endmodule

module led_shift_checker (
  input logic clk,
  input logic rst_n,
  input logic data_wr,
  input logic flash_en,
  input logic busy,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_latch
);
  assert_clk_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> busy);
  assert_data_stable_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));
  assert_latch_in_last_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch |=> !busy);
  assert_idle_outputs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_data && !ser_latch && !ser_clk));
  assert_start_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_wr || flash_en));
endmodule

bind serial_led_shifter led_shift_checker u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .flash_en(flash_en),
  .busy(busy), .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch)
);

// File: tb/tb_serial_led_shifter.sv
module tb_serial_led_shifter;
  localparam int NB = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          data_wr = 1'b0;
  logic [NB-1:0] data_in = '0;
  logic [1:0]    div_code = 2'd0;
  logic [4:0]    clk_delay = 5'd0;
  logic          flash_en = 1'b0;
  logic          latch_mode = 1'b0;
  logic [NB-1:0] pwm_vec = '0;
  logic busy, ser_clk, ser_data, ser_latch;

  serial_led_shifter dut (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
    .div_code(div_code), .clk_delay(clk_delay), .flash_en(flash_en),
    .latch_mode(latch_mode), .pwm_vec(pwm_vec), .busy(busy),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [NB-1:0] rx = '0;
  int rises = 0, bcyc = 0, lat = 0;
  logic psclk = 1'b0;

  always @(negedge clk) begin
    if (ser_clk && !psclk) begin
      rx = {rx[NB-2:0], ser_data};
      rises++;
    end
    psclk = ser_clk;
    if (busy) bcyc++;
    if (ser_latch) lat++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    rx = '0; rises = 0; bcyc = 0; lat = 0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
  endtask

  task automatic direct(input logic [NB-1:0] v);
    @(negedge clk);
    clr();
    data_in = v; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
    wait_idle();
  endtask

  function automatic int exp_busy(input int dc, input int dl);
    int d = 4 << dc;
    int e = (dl > d/2 - 1) ? d/2 - 1 : dl;
    return 17*d + e + 1;
  endfunction

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NB-1:0] pats [4];
    int dls [4];
    bit seen;
    pats[0] = 17'h1ABCD; pats[1] = 17'h00001; pats[2] = 17'h10000; pats[3] = 17'h15555;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !ser_clk && !ser_data && !ser_latch, "R1 reset outputs",
          {busy, ser_clk, ser_data, ser_latch}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !ser_clk && !ser_data && !ser_latch, "R1 idle outputs",
          {busy, ser_clk, ser_data, ser_latch}, 0);

    // R2 R3 R4 R9 sweep over divider, delay, pattern, latch mode
    for (int dc = 0; dc < 4; dc++) begin
      dls[0] = 0; dls[1] = 1; dls[2] = (4 << dc)/2 - 1; dls[3] = 31;
      for (int di = 0; di < 4; di++) begin
        for (int p = 0; p < 4; p++) begin
          div_code = 2'(dc); clk_delay = 5'(dls[di]); latch_mode = p[0];
          direct(pats[p]);
          check(rx == pats[p], "R2 received word", rx, pats[p]);
          check(rises == NB, "R2 rising edge count", rises, NB);
          check(bcyc == exp_busy(dc, dls[di]), "R3/R4 busy length", bcyc, exp_busy(dc, dls[di]));
          check(lat == (p[0] ? 1 : 0), "R9 latch pulses", lat, p[0]);
        end
      end
    end

    // R5 R10 write and config change during transfer
    div_code = 2'd1; clk_delay = 5'd2; latch_mode = 1'b0;
    @(negedge clk);
    clr();
    data_in = 17'h0F0F0; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
    repeat (30) @(negedge clk);
    data_in = 17'h1FFFF; data_wr = 1'b1; div_code = 2'd3; clk_delay = 5'd9; latch_mode = 1'b1;
    @(negedge clk); data_wr = 1'b0;
    wait_idle();
    check(rx == 17'h0F0F0, "R5 ignored write", rx, 17'h0F0F0);
    check(bcyc == exp_busy(1, 2), "R10 captured config", bcyc, exp_busy(1, 2));
    check(lat == 0, "R10 captured latch mode", lat, 0);
    quiet(40, seen);
    check(!seen, "R5 no second transfer", seen, 0);

    // Flash mode
    div_code = 2'd0; clk_delay = 5'd0; latch_mode = 1'b0;
    direct('0);
    pwm_vec = '0; flash_en = 1'b1;
    quiet(40, seen);
    check(!seen, "R6 zero vector no shift", seen, 0);
    clr();
    pwm_vec = 17'h12345;
    @(negedge clk);
    check(busy, "R7 flash start", busy, 1);
    wait_idle();
    check(rx == 17'h12345, "R7 flash word", rx, 17'h12345);
    quiet(40, seen);
    check(!seen, "R6 repeated vector no shift", seen, 0);
    clr();
    pwm_vec = 17'h00F00;
    @(negedge clk); wait_idle();
    check(rx == 17'h00F00 && rises == NB, "R7 second flash word", rx, 17'h00F00);
    clr(); rx = '1;
    pwm_vec = '0;
    @(negedge clk); wait_idle();
    check(rx == '0 && rises == NB, "R7 return to zero", rx, 0);
    flash_en = 1'b0;
    pwm_vec = 17'h0AAAA;
    quiet(40, seen);
    check(!seen, "R8 flash off no shift", seen, 0);
    flash_en = 1'b1;
    clr();
    @(negedge clk); wait_idle();
    check(rx == 17'h0AAAA, "R7 refresh after re-enable", rx, 17'h0AAAA);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule